// File: doc/BRIEF.md
# Deglitched I2C Register-File Slave

This block is a two-wire serial slave that gives a bus host read and write access to a small bank of 8-bit configuration registers. All of its logic runs on one fast local reference clock. The raw SCL and SDA pins are oversampled on that clock and passed through an agreement filter. A level change is accepted only after it has held for a fixed number of reference clocks, so a pulse that is too short never counts as a bus edge. Every protocol decision is made on the filtered, delayed copies of the two lines.

A host opens a transfer with a START and sends the 7-bit device address and a direction bit. In a write, the first data byte loads a register pointer, and each following byte is stored at the pointer. In a read, bytes are returned starting at the pointer. The pointer advances by one after each data byte in either direction. It is kept across STOP and repeated START, so the host can set it in a write and then turn the bus around with a repeated START to read from that index. SDA is open drain: the block only ever asserts an enable that pulls the line low.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe` = 0), and all registers read back as 0x00.
- R2: Before any START, and after an address byte that does not match `DEV_ADDR`, the slave never drives SDA: it neither acknowledges nor transmits until the next START.
- R3: A START followed by an address byte whose upper 7 bits equal `DEV_ADDR` is acknowledged: SDA is held low during the ninth clock. The low bit of that byte selects read (1) or write (0).
- R4: In a write, the first data byte loads the pointer. Each later byte is stored at the pointer and then the pointer advances by one. Every data byte is acknowledged.
- R5: In a read, the slave sends the register at the pointer, MSB first, and advances the pointer after each byte. It sends the next register whenever the host acknowledges.
- R6: A repeated START ends the current transfer and starts a new address phase with the pointer unchanged. The pointer is also kept across STOP.
- R7: Valid indices are 0x00 to NUM_REGS-1 (0x1B by default). A write at a higher index is dropped, and a read there returns 0x00. The 8-bit pointer wraps from 0xFF to 0x00.
- R8: If the host answers a read byte with a NACK (SDA high on the ninth clock), the slave releases SDA and drives nothing until the next START.
- R9: SCL and SDA pulses shorter than FILT reference clocks (3 by default) are not treated as edges and do not disturb a transfer.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: A STOP releases SDA and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock used to sample and filter the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock level from the pad |
| sda_i | input | 1 | Raw serial data level from the pad (wired-AND bus value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; the slave never drives it high |

## Verification
On every cycle, the assertions check four things. The drive enable can only rise while filtered SCL is low. Idle means SDA is released. A START always leaves the slave released and back in the address phase. Each transmitted byte advances the pointer by exactly one. Only the bench scenarios can show the end-to-end effects: address matching and acknowledge timing, pointer loading and its survival across a repeated START and a STOP, the dropped writes and zero reads past the top of the bank, pointer wrap, the silent bus after a NACK, and a write that still lands intact while short SCL spikes are injected.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int NUM_REGS = 28,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int IW = $clog2(NUM_REGS);
  localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACKD, S_TX, S_TXACK, S_TXLD} st_t;

  logic [FILT-1:0] scl_sh, sda_sh;
  logic scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1; sda_sh <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[FILT-2:0], scl_i};
      sda_sh <= {sda_sh[FILT-2:0], sda_i};
      if (&scl_sh) scl_f <= 1'b1; else if (~|scl_sh) scl_f <= 1'b0;
      if (&sda_sh) sda_f <= 1'b1; else if (~|sda_sh) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;
  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  st_t        state;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] txsh, ptr;
  logic       rw, addr_ph, ptr_ph;
  logic [7:0] regs [NUM_REGS];

  wire [7:0] rx_byte = {sh, sda_f};
  wire [7:0] rdata   = (ptr <= LAST) ? regs[ptr[IW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; sda_oe <= 1'b0; bitcnt <= '0; sh <= '0; txsh <= '0;
      ptr <= '0; rw <= 1'b0; addr_ph <= 1'b1; ptr_ph <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
    end else if (start_det) begin
      state <= S_RX; bitcnt <= '0; sda_oe <= 1'b0; addr_ph <= 1'b1;
    end else if (stop_det) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: if (scl_rise) begin
          sh <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            state <= S_ACKW;
            if (addr_ph) begin
              if (rx_byte[7:1] == DEV_ADDR) begin
                rw <= rx_byte[0]; addr_ph <= 1'b0; ptr_ph <= 1'b1;
              end else state <= S_IDLE;
            end else if (ptr_ph) begin
              ptr <= rx_byte; ptr_ph <= 1'b0;
            end else begin
              if (ptr <= LAST) regs[ptr[IW-1:0]] <= rx_byte;
              ptr <= ptr + 8'd1;
            end
          end
        end
        S_ACKW: if (scl_fall) begin
          sda_oe <= 1'b1; state <= S_ACKD;
        end
        S_ACKD: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            txsh <= rdata; sda_oe <= ~rdata[7]; state <= S_TX;
          end else begin
            sda_oe <= 1'b0; state <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0; bitcnt <= '0; ptr <= ptr + 8'd1; state <= S_TXACK;
          end else begin
            sda_oe <= ~txsh[6]; txsh <= {txsh[6:0], 1'b0}; bitcnt <= bitcnt + 3'd1;
          end
        end
        S_TXACK: if (scl_rise) state <= sda_f ? S_IDLE : S_TXLD;
        S_TXLD: if (scl_fall) begin
          txsh <= rdata; sda_oe <= ~rdata[7]; state <= S_TX;
        end
        default: ;
      endcase
    end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe); // R11
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_det) |-> (!sda_oe && state == S_RX)); // R6
  AST_TX_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXACK && $past(state) == S_TX) |-> ptr == $past(ptr) + 8'd1); // R5
endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_regfile_slave u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

  int nchk = 0, nfail = 0, oe_hits = 0, r10_viol = 0;
  logic watch = 1'b0, oe_prev = 1'b0, ack;
  logic [7:0] got, rd;
  logic [7:0] exp_q[$];
  string req_q[$];
  event rd_ev;

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (watch && sda_oe) oe_hits++;
    if (scl_m && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev = sda_oe;
  end

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) check_eq("scoreboard-underflow", 32'(got), 32'hFFFF);
    else check_eq(req_q.pop_front(), 32'(got), 32'(exp_q.pop_front()));
  end

  task automatic hp(); repeat (20) @(negedge clk); endtask

  task automatic send_bit(input logic b, input logic g);
    sda_m = b; hp();
    if (g) begin scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0; hp(); end
    scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); b = sda_bus; scl_m = 1'b0; hp();
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic write_byte(input logic [7:0] b, input logic g, output logic a);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i], g);
    recv_bit(s);
    a = ~s;
  endtask

  task automatic wr_ack(input logic [7:0] b, input string req);
    logic a;
    write_byte(b, 1'b0, a);
    check_eq(req, 32'(a), 32'd1);
  endtask

  task automatic read_expect(input logic [7:0] v, input logic nack, input string req);
    logic s;
    exp_q.push_back(v); req_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin recv_bit(s); rd[i] = s; end
    got = rd; ->rd_ev;
    sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic set_ptr_read(input logic [7:0] p);
    i2c_start(); wr_ack(8'h58, "R3 write address ack"); wr_ack(p, "R4 pointer ack");
    i2c_start(); wr_ack(8'h59, "R3 read address ack");
  endtask

  initial begin
    logic s;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R1 sda released after reset", 32'(sda_oe), 32'd0);

    // R2: bits clocked with no START
    scl_m = 1'b0; hp(); watch = 1'b1;
    for (int i = 7; i >= 0; i--) send_bit(8'h58 >> i, 1'b0);
    recv_bit(s);
    watch = 1'b0; scl_m = 1'b1; hp();
    check_eq("R2 no drive before START", 32'(oe_hits), 32'd0);

    // R2: wrong address
    i2c_start(); write_byte(8'h5A, 1'b0, ack);
    check_eq("R2 wrong address no ack", 32'(ack), 32'd0);
    oe_hits = 0; watch = 1'b1;
    write_byte(8'h00, 1'b0, ack);
    watch = 1'b0;
    check_eq("R2 ignored after mismatch", 32'(oe_hits), 32'd0);
    i2c_stop();

    // R1: registers read as zero
    set_ptr_read(8'h00);
    read_expect(8'h00, 1'b0, "R1 reg0 reset value");
    read_expect(8'h00, 1'b1, "R1 reg1 reset value");
    i2c_stop();

    // R4: write burst
    i2c_start(); wr_ack(8'h58, "R3 write address ack"); wr_ack(8'h02, "R4 pointer ack");
    wr_ack(8'hA5, "R4 data ack"); wr_ack(8'h3C, "R4 data ack");
    wr_ack(8'h71, "R4 data ack"); wr_ack(8'hE4, "R4 data ack");
    i2c_stop();
    check_eq("R11 released after STOP", 32'(sda_oe), 32'd0);

    // R5/R6: repeated START read, then pointer kept across STOP
    set_ptr_read(8'h02);
    read_expect(8'hA5, 1'b0, "R6 read after repeated START");
    read_expect(8'h3C, 1'b1, "R5 auto-increment read");
    i2c_stop();
    i2c_start(); wr_ack(8'h59, "R3 read address ack");
    read_expect(8'h71, 1'b0, "R6 pointer kept across STOP");
    read_expect(8'hE4, 1'b1, "R5 auto-increment read");
    i2c_stop();

    // R7: top of bank
    i2c_start(); wr_ack(8'h58, "R3 write address ack"); wr_ack(8'h1B, "R4 pointer ack");
    wr_ack(8'h11, "R4 data ack"); wr_ack(8'h22, "R7 out-of-range write ack");
    i2c_stop();
    set_ptr_read(8'h1A);
    read_expect(8'h00, 1'b0, "R7 reg 0x1A");
    read_expect(8'h11, 1'b0, "R7 last register");
    read_expect(8'h00, 1'b1, "R7 beyond bank reads zero");
    i2c_stop();

    // R7: pointer wrap
    i2c_start(); wr_ack(8'h58, "R3 write address ack"); wr_ack(8'hFF, "R4 pointer ack");
    wr_ack(8'h99, "R7 data ack"); wr_ack(8'h77, "R7 data ack after wrap");
    i2c_stop();
    set_ptr_read(8'hFF);
    read_expect(8'h00, 1'b0, "R7 index 0xFF reads zero");
    read_expect(8'h77, 1'b1, "R7 wrapped write landed at 0x00");
    i2c_stop();

    // R8: NACK ends read
    set_ptr_read(8'h02);
    read_expect(8'hA5, 1'b1, "R8 byte before NACK");
    check_eq("R8 released after NACK", 32'(sda_oe), 32'd0);
    oe_hits = 0; watch = 1'b1;
    for (int i = 0; i < 9; i++) recv_bit(s);
    watch = 1'b0;
    check_eq("R8 silent after NACK", 32'(oe_hits), 32'd0);
    i2c_stop();

    // R9: short SCL spikes on every bit
    i2c_start(); wr_ack(8'h58, "R3 write address ack"); wr_ack(8'h06, "R4 pointer ack");
    write_byte(8'h5A, 1'b1, ack);
    check_eq("R9 glitched byte ack", 32'(ack), 32'd1);
    i2c_stop();
    set_ptr_read(8'h06);
    read_expect(8'h5A, 1'b1, "R9 glitched byte intact");
    i2c_stop();

    check_eq("R10 drive changes only while SCL low", 32'(r10_viol), 32'd0);
    hp();
    check_eq("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule